// File: doc/BRIEF.md
# YCbCr 4:2:2 to 4:4:4 Chroma Upsampler

This block takes a 4:2:2 YCbCr pixel stream at one pixel per clock and turns it into a 4:4:4 stream. Each input pixel carries a luma sample and one chroma sample. Pixels are grouped in pairs. The first pixel of a pair carries the Cb sample for the pair, and the second carries the Cr sample. Both pixels share both chroma values. A data-enable input frames the active pixels. Horizontal and vertical sync travel alongside the data and are delayed by the same amount.

Pair alignment is derived inside the block. The pixel at which data-enable rises always starts a pair, so a line with an odd pixel count cannot shift the phase of the line after it.

A mode input picks how the chroma missing from the second pixel of a pair is filled in:
- Repetition copies the pair's own samples.
- Interpolation takes the rounded mean of the current pair's sample and the next pair's sample, where a next pair exists on the same line.

The component width is a parameter of up to 12 bits.

Top module: `chroma_upsampler`

## Requirements
- R1: A pixel sampled at rising clock edge n appears on out_y/out_cb/out_cr after rising edge n+3. out_de, out_hs and out_vs carry the in_de, in_hs and in_vs values sampled at edge n in the same cycle.
- R2: The first pixel with in_de high after a cycle with in_de low is an even pixel (its in_c is Cb). The pixels then alternate even/odd (in_c is Cr on odd pixels) until in_de falls.
- R3: With interp_en low, the odd pixel of a pair outputs the same Cb and Cr as the even pixel of that pair. These are the Cb from the even pixel and the Cr from the odd pixel.
- R4: With interp_en high, an odd pixel that has two further active pixels on its line outputs Cb = (Cb_k + Cb_k+1 + 1) >> 1 and Cr = (Cr_k + Cr_k+1 + 1) >> 1. The sum is computed without overflow at full width.
- R5: With interp_en high, an odd pixel with fewer than two further active pixels on its line uses repetition, as in R3.
- R6: An even pixel that is the last active pixel of its line outputs its own Cb. Its Cr is the Cr most recently output with out_de high, or zero if none has been output since reset.
- R7: While out_de is low, out_y, out_cb and out_cr are zero.
- R8: While rst_n is low, every output is zero.
- R9: An even pixel always outputs its own in_c as Cb and the following odd pixel's in_c as Cr, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_en | input | 1 | 1 = interpolate missing chroma, 0 = repeat; hold stable through a line |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_y | input | W | Input luma |
| in_c | input | W | Input chroma, Cb on even pixels and Cr on odd pixels |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_y | output | W | Output luma |
| out_cb | output | W | Output Cb |
| out_cr | output | W | Output Cr |

## Verification
If the phase state is wrong, Cb and Cr swap on the first pair of a line. That error shows on out_cb and out_cr three edges after the rising edge of in_de. The odd-length line followed by a second line is built to expose it.

If the pair-Cb or Cr hold registers are wrong, the error shows one output pixel later: on the odd pixel of the pair, or on a lone last pixel.

A wrong look-ahead decision shows only on the final pair of a line in interpolation mode.

A delay mismatch in the control path shifts out_de against the data at the first pixel of every line.

// File: rtl/cup_pkg.sv
package cup_pkg;
  // widest component the arithmetic supports
  localparam int unsigned MAX_CW = 12;

  // rounded mean of two samples, computed one bit wider so nothing overflows
  function automatic logic [MAX_CW-1:0] mid_round(input logic [MAX_CW-1:0] a,
                                                  input logic [MAX_CW-1:0] b);
    logic [MAX_CW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{MAX_CW{1'b0}}, 1'b1};
    return s[MAX_CW:1];
  endfunction
endpackage

// File: rtl/cup_phase.sv
module cup_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic de,
  output logic odd,
  output logic line_start
);
  logic de_q;
  logic odd_q;

  assign line_start = de && !de_q;
  assign odd        = de && de_q && !odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      de_q  <= de;
      odd_q <= odd;
    end
  end

  // R2
  start_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> !odd);
endmodule

// File: rtl/cup_pipe.sv
module cup_pipe #(
  parameter int unsigned SW    = 28,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] taps [DEPTH]
);
  logic [SW-1:0] st [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
    assign taps[g] = st[g];
  end
endmodule

// File: rtl/cup_recon.sv
module cup_recon
  import cup_pkg::*;
#(
  parameter int unsigned W = 12,
  localparam int unsigned SW = 4 + 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          interp_en,
  input  logic [SW-1:0] tgt,
  input  logic [SW-1:0] nxt1,
  input  logic [SW-1:0] nxt2,
  output logic          o_de,
  output logic          o_hs,
  output logic          o_vs,
  output logic          o_odd,
  output logic          o_interp,
  output logic [W-1:0]  o_y,
  output logic [W-1:0]  o_cb,
  output logic [W-1:0]  o_cr
);
  localparam int unsigned B_DE  = SW - 1;
  localparam int unsigned B_HS  = SW - 2;
  localparam int unsigned B_VS  = SW - 3;
  localparam int unsigned B_ODD = SW - 4;

  logic         t_de;
  logic         t_odd;
  logic [W-1:0] t_y;
  logic [W-1:0] t_c;
  logic [W-1:0] n1_c;
  logic [W-1:0] n2_c;
  logic         ahead_ok;
  logic         use_mid;
  logic [W-1:0] pair_cb;
  logic [W-1:0] cr_hold;
  logic [W-1:0] y_n;
  logic [W-1:0] cb_n;
  logic [W-1:0] cr_n;
  logic [MAX_CW-1:0] mid_cb;
  logic [MAX_CW-1:0] mid_cr;

  assign t_de  = tgt[B_DE];
  assign t_odd = tgt[B_ODD];
  assign t_y   = tgt[2*W-1:W];
  assign t_c   = tgt[W-1:0];
  assign n1_c  = nxt1[W-1:0];
  assign n2_c  = nxt2[W-1:0];

  // both chroma samples of the next pair are on this line
  assign ahead_ok = nxt1[B_DE] && nxt2[B_DE];
  assign use_mid  = interp_en && t_odd && ahead_ok;

  assign mid_cb = mid_round(MAX_CW'(pair_cb), MAX_CW'(n1_c));
  assign mid_cr = mid_round(MAX_CW'(t_c), MAX_CW'(n2_c));

  always_comb begin
    y_n  = '0;
    cb_n = '0;
    cr_n = '0;
    if (t_de) begin
      y_n = t_y;
      if (!t_odd) begin
        cb_n = t_c;
        cr_n = nxt1[B_DE] ? n1_c : cr_hold;
      end else if (use_mid) begin
        cb_n = mid_cb[W-1:0];
        cr_n = mid_cr[W-1:0];
      end else begin
        cb_n = pair_cb;
        cr_n = t_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_cb  <= '0;
      cr_hold  <= '0;
      o_de     <= 1'b0;
      o_hs     <= 1'b0;
      o_vs     <= 1'b0;
      o_odd    <= 1'b0;
      o_interp <= 1'b0;
      o_y      <= '0;
      o_cb     <= '0;
      o_cr     <= '0;
    end else begin
      if (t_de && !t_odd) pair_cb <= t_c;
      if (t_de)           cr_hold <= cr_n;
      o_de     <= t_de;
      o_hs     <= tgt[B_HS];
      o_vs     <= tgt[B_VS];
      o_odd    <= t_odd;
      o_interp <= interp_en;
      o_y      <= y_n;
      o_cb     <= cb_n;
      o_cr     <= cr_n;
    end
  end

  // R7
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !o_de |-> (o_y == '0 && o_cb == '0 && o_cr == '0));
endmodule

// File: rtl/chroma_upsampler.sv
module chroma_upsampler #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         interp_en,
  input  logic         in_de,
  input  logic         in_hs,
  input  logic         in_vs,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_c,
  output logic         out_de,
  output logic         out_hs,
  output logic         out_vs,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_cb,
  output logic [W-1:0] out_cr
);
  localparam int unsigned SW    = 4 + 2 * W;
  localparam int unsigned DEPTH = 3;

  logic          in_odd;
  logic          line_start;
  logic [SW-1:0] stage_in;
  logic [SW-1:0] taps [DEPTH];
  logic          out_odd;
  logic          out_interp;

  cup_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .de         (in_de),
    .odd        (in_odd),
    .line_start (line_start)
  );

  assign stage_in = {in_de, in_hs, in_vs, in_odd, in_y, in_c};

  cup_pipe #(.SW(SW), .DEPTH(DEPTH)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (stage_in),
    .taps  (taps)
  );

  cup_recon #(.W(W)) u_recon (
    .clk       (clk),
    .rst_n     (rst_n),
    .interp_en (interp_en),
    .tgt       (taps[2]),
    .nxt1      (taps[1]),
    .nxt2      (taps[0]),
    .o_de      (out_de),
    .o_hs      (out_hs),
    .o_vs      (out_vs),
    .o_odd     (out_odd),
    .o_interp  (out_interp),
    .o_y       (out_y),
    .o_cb      (out_cb),
    .o_cr      (out_cr)
  );

  // cycles since reset, saturating, so $past never reaches before reset
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  // R1
  ctl_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || warm != 3'd4)
    (out_de == $past(in_de, 4) && out_hs == $past(in_hs, 4) && out_vs == $past(in_vs, 4)));

  // R2
  line_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_de) |-> !out_odd);

  // R2
  odd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_de && out_odd) |-> $past(out_de) && !$past(out_odd));

  // R3
  repeat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_de && out_odd && !out_interp) |-> (out_cb == $past(out_cb) && out_cr == $past(out_cr)));
endmodule

// File: tb/chroma_upsampler_bench.sv
module chroma_upsampler_bench;
  localparam int W = 12;
  localparam int MAXN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interp_en = 1'b0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [W-1:0] in_y = '0, in_c = '0;
  logic out_de, out_hs, out_vs;
  logic [W-1:0] out_y, out_cb, out_cr;

  always #10 clk = ~clk;

  chroma_upsampler #(.W(W)) u_chroma_upsampler (
    .clk(clk), .rst_n(rst_n), .interp_en(interp_en),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_y(in_y), .in_c(in_c),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // stimulus buffer for one run
  int n;
  logic s_de [MAXN], s_hs [MAXN], s_vs [MAXN];
  logic [W-1:0] s_y [MAXN], s_c [MAXN];
  logic [W-1:0] e_y [MAXN], e_cb [MAXN], e_cr [MAXN];
  logic [W-1:0] last_cr = '0;

  function automatic logic [W-1:0] avg(input logic [W-1:0] a, input logic [W-1:0] b);
    int s;
    s = int'(a) + int'(b) + 1;
    return W'(s / 2);
  endfunction

  task automatic clear();
    n = 0;
  endtask

  task automatic px(input logic de, input logic hs, input logic vs,
                    input int y, input int c);
    s_de[n] = de; s_hs[n] = hs; s_vs[n] = vs;
    s_y[n] = W'(y); s_c[n] = W'(c);
    n++;
  endtask

  task automatic idle(input int k, input logic hs, input logic vs);
    for (int i = 0; i < k; i++) px(1'b0, hs, vs, 7, 9);
  endtask

  task automatic line(input int len, input int ybase, input int cbase);
    for (int i = 0; i < len; i++) px(1'b1, 1'b0, 1'b0, ybase + i, cbase + 37 * i);
  endtask

  // expected values from the requirements
  task automatic model(input logic mode);
    int j;
    logic a1, a2;
    j = 0;
    for (int i = 0; i < n; i++) begin
      e_y[i] = '0; e_cb[i] = '0; e_cr[i] = '0;
      if (s_de[i]) begin
        j = (i == 0 || !s_de[i-1]) ? 0 : j + 1;
        a1 = (i + 1 < n) && s_de[i+1];
        a2 = a1 && (i + 2 < n) && s_de[i+2];
        e_y[i] = s_y[i];
        if (j % 2 == 0) begin
          e_cb[i] = s_c[i];
          e_cr[i] = a1 ? s_c[i+1] : last_cr;
        end else if (mode && a2) begin
          e_cb[i] = avg(s_c[i-1], s_c[i+1]);
          e_cr[i] = avg(s_c[i], s_c[i+2]);
        end else begin
          e_cb[i] = s_c[i-1];
          e_cr[i] = s_c[i];
        end
        last_cr = e_cr[i];
      end
    end
  endtask

  task automatic check_cycle(input string tag, input int i);
    total++;
    if (out_de !== s_de[i] || out_hs !== s_hs[i] || out_vs !== s_vs[i] ||
        out_y !== e_y[i] || out_cb !== e_cb[i] || out_cr !== e_cr[i]) begin
      bad++;
      $display("FAIL %s px%0d: got de=%b hs=%b vs=%b y=%0d cb=%0d cr=%0d exp de=%b hs=%b vs=%b y=%0d cb=%0d cr=%0d",
               tag, i, out_de, out_hs, out_vs, out_y, out_cb, out_cr,
               s_de[i], s_hs[i], s_vs[i], e_y[i], e_cb[i], e_cr[i]);
    end
  endtask

  // drive the buffer; output of input sampled at edge n is checked after edge n+3
  task automatic run(input string tag, input logic mode);
    model(mode);
    interp_en = mode;
    for (int c = 0; c < n + 4; c++) begin
      @(negedge clk);
      if (c >= 4) check_cycle(tag, c - 4);
      if (c < n) begin
        in_de = s_de[c]; in_hs = s_hs[c]; in_vs = s_vs[c];
        in_y = s_y[c]; in_c = s_c[c];
      end else begin
        in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0; in_y = '0; in_c = '0;
      end
    end
  endtask

  task automatic t_reset();
    in_de = 1'b1; in_y = 12'd100; in_c = 12'd200;
    repeat (3) @(negedge clk);
    total++;
    if ({out_de, out_hs, out_vs} !== 3'b000 || out_y !== '0 || out_cb !== '0 || out_cr !== '0) begin
      bad++;
      $display("FAIL R8 reset: got de=%b y=%0d cb=%0d cr=%0d exp all zero", out_de, out_y, out_cb, out_cr);
    end
    in_de = 1'b0; in_y = '0; in_c = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_repeat();   // R3 R9 R1
    clear(); idle(2, 1'b1, 1'b0); idle(1, 1'b0, 1'b0); line(8, 16, 100); idle(2, 1'b0, 1'b0);
    run("R3", 1'b0);
  endtask

  task automatic t_interp();   // R4 R5 R9
    clear(); idle(1, 1'b0, 1'b0); line(8, 40, 300); idle(1, 1'b0, 1'b0);
    run("R4", 1'b1);
  endtask

  task automatic t_extremes(); // R4 rounding at full scale
    clear(); idle(1, 1'b0, 1'b0);
    px(1'b1, 1'b0, 1'b0, 4095, 4095); px(1'b1, 1'b0, 1'b0, 0, 4094);
    px(1'b1, 1'b0, 1'b0, 1, 4094);    px(1'b1, 1'b0, 1'b0, 2, 4095);
    px(1'b1, 1'b0, 1'b0, 3, 0);       px(1'b1, 1'b0, 1'b0, 4, 1);
    px(1'b1, 1'b0, 1'b0, 5, 1);       px(1'b1, 1'b0, 1'b0, 6, 2);
    idle(1, 1'b0, 1'b0);
    run("R4", 1'b1);
  endtask

  task automatic t_odd_len();  // R2 R6 R5
    clear(); idle(1, 1'b0, 1'b0); line(5, 60, 500); idle(1, 1'b1, 1'b0); line(6, 90, 900); idle(1, 1'b0, 1'b0);
    run("R2", 1'b1);
  endtask

  task automatic t_lone();     // R6
    clear(); idle(2, 1'b0, 1'b1); line(1, 77, 1234); idle(2, 1'b0, 1'b0); line(3, 5, 50);
    run("R6", 1'b0);
  endtask

  task automatic t_blank();    // R7 R1
    clear();
    idle(1, 1'b1, 1'b1); idle(1, 1'b0, 1'b1); idle(1, 1'b1, 1'b0); idle(1, 1'b0, 1'b0);
    line(4, 200, 2000); idle(3, 1'b1, 1'b0);
    run("R7", 1'b0);
  endtask

  task automatic t_switch();   // R3 then R4 on the same data
    clear(); idle(1, 1'b0, 1'b0); line(6, 11, 3000); idle(1, 1'b0, 1'b0);
    run("R3", 1'b0);
    run("R4", 1'b1);
  endtask

  initial begin
    t_reset();
    t_repeat();
    t_interp();
    t_extremes();
    t_odd_len();
    t_lone();
    t_blank();
    t_switch();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule